// File: doc/BRIEF.md
# Descriptor-Chained XOR / Copy / Fill Engine

This block is a single-channel memory engine. It reads a linked list of descriptors from memory. For each descriptor it combines source buffers into a destination buffer, either by XOR or as a plain copy, and then hands the descriptor back to software. A third mode fills a block with a 64-bit pattern and uses no descriptors. In that mode the destination, the size and the pattern all come from registers.

Software programs the engine through a small word-indexed register file. It chooses the mode, writes the address of the first descriptor and sets the start bit. The engine then drives a word-wide memory port that carries one access at a time. For every word of the buffer it reads each enabled source in ascending index order, folds the values into a one-word accumulator and writes the result. It then writes the descriptor's status word back and follows the link word. Two single-cycle pulses report progress: one when a descriptor is finished and one when the chain ends.

Top module: `xor_copy_engine`

## Requirements
- R1: After reset the engine is idle. The control register (index 1) reads zero, as do the configuration register (index 0) and the current-descriptor register (index 3). No memory request is raised.
- R2: The configuration register (index 0) stores all 32 written bits and reads them back. Bits [2:0] select the mode: 0 = copy, 1 = XOR, 4 = fill. Any other value behaves as copy.
- R3: Writing the control register with bit 0 set starts an idle engine. While the engine is running, bits [5:4] read 01; when it is idle they read 00. A start write made while the engine is running is ignored: the descriptor pointer register (index 2) is not consumed and nothing new is fetched.
- R4: A descriptor is a block of words at 4-byte steps from its base: word 0 status, word 1 command, word 2 byte count, word 3 destination, word 4 link, words 5..12 source addresses 0..7.
- R5: In XOR mode each destination word is the XOR of the same word from every source i whose command bit i is set. Sources are read in ascending index order before the word is written. A command with no source bits set writes zeros.
- R6: In copy mode only source 0 is read, and the command's source bits are ignored.
- R7: When a descriptor is finished the engine writes its status word with bit 31 = 0 and bit 30 = length error. The end-of-descriptor output pulses for one cycle, in the cycle after that write is accepted.
- R8: A nonzero link sends the engine on to the next descriptor. A zero link returns the engine to idle, and the end-of-chain output pulses in the same cycle as the last end-of-descriptor pulse.
- R9: The current-descriptor register (index 3) reads the base address of the descriptor being processed, or of the last one processed.
- R10: Fill mode writes size/4 words starting at the fill destination (index 4), with the size in register index 5. Even word offsets take the low half (index 6) and odd offsets the high half (index 7). Fill mode performs no memory reads, does not pulse end-of-descriptor, pulses end-of-chain once and leaves the current-descriptor register unchanged.
- R11: A byte count below MIN_BYTES, above MAX_BYTES or not a multiple of 4 moves no data. The descriptor still completes with status bit 30 set, and the chain continues. Counts equal to MIN_BYTES or MAX_BYTES are accepted. A fill size that breaks the same rule writes nothing and only pulses end-of-chain.
- R12: A start with the descriptor pointer register at zero and a nonzero current descriptor re-reads that descriptor's link word. If the link is nonzero, processing resumes there. If it is zero, the engine returns to idle with no pulse. A start that uses the pointer register clears it to zero.
- R13: A memory request held without acknowledge keeps its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Memory read data |
| eod_pulse | output | 1 | One-cycle end-of-descriptor pulse |
| eoc_pulse | output | 1 | One-cycle end-of-chain pulse |

## Verification
Two events can fall in the same cycle. First, the status write-back of a descriptor whose link is zero raises end-of-descriptor and end-of-chain together. Every single-descriptor run in the XOR mask sweep provokes this, and the bench judges it by checking that both pulse counters advance by exactly one. Second, a start write can arrive while the engine is still streaming a long descriptor. The bench provokes this in mid-transfer and judges it by reading back the still-loaded pointer register and the untouched status word of the descriptor it points at.

// File: rtl/xce_pkg.sv
// Shared constants and types for the descriptor-chained XOR/copy/fill engine.
// Assumes 32-bit words and byte addresses aligned to 4.
package xce_pkg;
    localparam int DW = 32;

    // Mode encodings held in configuration bits [2:0]
    localparam logic [2:0] MODE_COPY = 3'd0;
    localparam logic [2:0] MODE_XOR  = 3'd1;
    localparam logic [2:0] MODE_FILL = 3'd4;

    // Word offsets inside a descriptor
    localparam int OFS_STATUS = 0;
    localparam int OFS_CMD    = 1;
    localparam int OFS_COUNT  = 2;
    localparam int OFS_DEST   = 3;
    localparam int OFS_NEXT   = 4;
    localparam int OFS_SRC    = 5;

    // Register indices
    localparam logic [2:0] REG_CFG   = 3'd0;
    localparam logic [2:0] REG_CTRL  = 3'd1;
    localparam logic [2:0] REG_PTR   = 3'd2;
    localparam logic [2:0] REG_CUR   = 3'd3;
    localparam logic [2:0] REG_FDST  = 3'd4;
    localparam logic [2:0] REG_FSIZE = 3'd5;
    localparam logic [2:0] REG_FLO   = 3'd6;
    localparam logic [2:0] REG_FHI   = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LINK, ST_FETCH, ST_SRC, ST_DST, ST_STAT, ST_FILL
    } xce_state_e;
endpackage

// File: rtl/xce_regs.sv
// Register file for the engine: configuration, control/state, descriptor
// pointer, current-descriptor readback and fill parameters.
// Assumes a single write port and a combinational read port.
module xce_regs
    import xce_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    waddr,
    input  logic [DW-1:0] wdata,
    input  logic [2:0]    raddr,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic [DW-1:0] curr,
    input  logic          ptr_take,
    output logic          start,
    output logic [2:0]    mode,
    output logic [DW-1:0] ptr,
    output logic [DW-1:0] fill_dst,
    output logic [DW-1:0] fill_size,
    output logic [DW-1:0] fill_lo,
    output logic [DW-1:0] fill_hi
);
    logic [DW-1:0] cfg_q;

    assign mode  = cfg_q[2:0];
    // A start request is honoured only while the engine is idle
    assign start = we && (waddr == REG_CTRL) && wdata[0] && !busy;

    // Register writes; a consumed pointer is cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            ptr       <= '0;
            fill_dst  <= '0;
            fill_size <= '0;
            fill_lo   <= '0;
            fill_hi   <= '0;
        end else begin
            if (ptr_take) ptr <= '0;
            if (we) begin
                case (waddr)
                    REG_CFG:   cfg_q     <= wdata;
                    REG_PTR:   ptr       <= wdata;
                    REG_FDST:  fill_dst  <= wdata;
                    REG_FSIZE: fill_size <= wdata;
                    REG_FLO:   fill_lo   <= wdata;
                    REG_FHI:   fill_hi   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer
    always_comb begin
        case (raddr)
            REG_CFG:   rdata = cfg_q;
            REG_CTRL:  rdata = {26'd0, (busy ? 2'b01 : 2'b00), 4'd0};
            REG_PTR:   rdata = ptr;
            REG_CUR:   rdata = curr;
            REG_FDST:  rdata = fill_dst;
            REG_FSIZE: rdata = fill_size;
            REG_FLO:   rdata = fill_lo;
            default:   rdata = fill_hi;
        endcase
    end
endmodule

// File: rtl/xce_core.sv
// Sequencer and data path: fetches descriptors, folds enabled sources into a
// one-word accumulator, writes destination words and status, follows links,
// and runs register-driven fill. Assumes one outstanding memory access.
module xce_core
    import xce_pkg::*;
#(
    parameter int NSRC      = 8,
    parameter int MIN_BYTES = 8,
    parameter int MAX_BYTES = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [DW-1:0] ptr,
    input  logic [DW-1:0] fill_dst,
    input  logic [DW-1:0] fill_size,
    input  logic [DW-1:0] fill_lo,
    input  logic [DW-1:0] fill_hi,
    output logic          ptr_take,
    output logic          busy,
    output logic [DW-1:0] curr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          eod,
    output logic          eoc
);
    localparam int FETCH_LAST = OFS_SRC + NSRC - 1;
    localparam int FW         = $clog2(FETCH_LAST + 1);
    localparam int SW         = $clog2(NSRC);

    xce_state_e     st;
    logic [2:0]     mode_q;
    logic [DW-1:0]  dptr, count_q, dst_q, nxt_q, acc;
    logic [DW-1:0]  src_q [NSRC];
    logic [NSRC-1:0] cmd_q;
    logic [FW-1:0]  widx;
    logic [SW-1:0]  si;
    logic [29:0]    word_q;
    logic           err_q, src_en, last_word;

    function automatic logic bad_len(input logic [DW-1:0] c);
        return (c < DW'(MIN_BYTES)) || (c > DW'(MAX_BYTES)) || (c[1:0] != 2'b00);
    endfunction

    assign busy      = (st != ST_IDLE);
    assign last_word = (word_q == (count_q[31:2] - 30'd1));
    assign src_en    = (mode_q == MODE_XOR) ? cmd_q[si] : (si == '0);
    assign ptr_take  = (st == ST_IDLE) && start && (mode != MODE_FILL) && (ptr != '0);

    // Memory access generated by the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_LINK:  begin mem_req = 1'b1; mem_addr = curr + DW'(OFS_NEXT * 4); end
            ST_FETCH: begin mem_req = 1'b1; mem_addr = dptr + (DW'(widx) << 2); end
            ST_SRC:   begin mem_req = src_en; mem_addr = src_q[si] + {word_q, 2'b00}; end
            ST_DST:   begin mem_req = 1'b1; mem_we = 1'b1;
                            mem_addr = dst_q + {word_q, 2'b00}; mem_wdata = acc; end
            ST_STAT:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dptr;
                            mem_wdata = {1'b0, err_q, 30'd0}; end
            ST_FILL:  begin mem_req = 1'b1; mem_we = 1'b1;
                            mem_addr = dst_q + {word_q, 2'b00};
                            mem_wdata = word_q[0] ? fill_hi : fill_lo; end
            default: ;
        endcase
    end

    // Sequencer: state, descriptor fields, accumulator and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; mode_q <= MODE_COPY; dptr <= '0; curr <= '0;
            count_q <= '0; dst_q <= '0; nxt_q <= '0; acc <= '0; cmd_q <= '0;
            widx <= '0; si <= '0; word_q <= '0; err_q <= 1'b0;
            eod <= 1'b0; eoc <= 1'b0;
            for (int i = 0; i < NSRC; i++) src_q[i] <= '0;
        end else begin
            eod <= 1'b0;
            eoc <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    mode_q <= mode; word_q <= '0; si <= '0; acc <= '0;
                    if (mode == MODE_FILL) begin
                        dst_q <= fill_dst; count_q <= fill_size;
                        if (bad_len(fill_size)) eoc <= 1'b1;
                        else st <= ST_FILL;
                    end else if (ptr != '0) begin
                        dptr <= ptr; curr <= ptr; widx <= FW'(OFS_CMD); st <= ST_FETCH;
                    end else if (curr != '0) begin
                        st <= ST_LINK;
                    end
                end
                ST_LINK: if (mem_ack) begin
                    if (mem_rdata != '0) begin
                        dptr <= mem_rdata; curr <= mem_rdata;
                        widx <= FW'(OFS_CMD); st <= ST_FETCH;
                    end else st <= ST_IDLE;
                end
                ST_FETCH: if (mem_ack) begin
                    if (widx == FW'(OFS_CMD))        cmd_q   <= mem_rdata[NSRC-1:0];
                    else if (widx == FW'(OFS_COUNT)) count_q <= mem_rdata;
                    else if (widx == FW'(OFS_DEST))  dst_q   <= mem_rdata;
                    else if (widx == FW'(OFS_NEXT))  nxt_q   <= mem_rdata;
                    else src_q[SW'(widx - FW'(OFS_SRC))] <= mem_rdata;
                    if (widx == FW'(FETCH_LAST)) begin
                        word_q <= '0; si <= '0; acc <= '0;
                        if (bad_len(count_q)) begin err_q <= 1'b1; st <= ST_STAT; end
                        else st <= ST_SRC;
                    end else widx <= widx + 1'b1;
                end
                ST_SRC: if (!src_en || mem_ack) begin
                    if (src_en) acc <= acc ^ mem_rdata;
                    if (si == SW'(NSRC - 1)) st <= ST_DST;
                    else si <= si + 1'b1;
                end
                ST_DST: if (mem_ack) begin
                    acc <= '0; si <= '0;
                    if (last_word) st <= ST_STAT;
                    else begin word_q <= word_q + 30'd1; st <= ST_SRC; end
                end
                ST_STAT: if (mem_ack) begin
                    eod <= 1'b1; err_q <= 1'b0;
                    if (nxt_q != '0) begin
                        dptr <= nxt_q; curr <= nxt_q; widx <= FW'(OFS_CMD); st <= ST_FETCH;
                    end else begin
                        eoc <= 1'b1; st <= ST_IDLE;
                    end
                end
                ST_FILL: if (mem_ack) begin
                    if (last_word) begin eoc <= 1'b1; st <= ST_IDLE; end
                    else word_q <= word_q + 30'd1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3: a start request from the register file only reaches an idle sequencer
    a_r3_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == ST_IDLE));
    // R1: an idle engine issues no memory traffic
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    // R13: an unacknowledged request holds address and direction
    a_r13_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R8: end-of-chain leaves the engine idle
    a_r8_eoc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> !busy);
    // R7: status write-back targets the current descriptor and releases ownership
    a_r7_status_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STAT && mem_req) |-> (mem_addr == curr && !mem_wdata[31]));
    // R10: fill never reads memory
    a_r10_fill_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |-> mem_we);
endmodule

// File: rtl/xor_copy_engine.sv
// Top level of the single-channel descriptor-chained XOR/copy/fill engine.
// Connects the register file to the sequencer; no logic of its own.
module xor_copy_engine
    import xce_pkg::*;
#(
    parameter int NSRC      = 8,
    parameter int MIN_BYTES = 8,
    parameter int MAX_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        eod_pulse,
    output logic        eoc_pulse
);
    logic          start, ptr_take, busy;
    logic [2:0]    mode;
    logic [DW-1:0] ptr, curr, fill_dst, fill_size, fill_lo, fill_hi;

    xce_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata), .busy(busy), .curr(curr),
        .ptr_take(ptr_take), .start(start), .mode(mode), .ptr(ptr),
        .fill_dst(fill_dst), .fill_size(fill_size), .fill_lo(fill_lo), .fill_hi(fill_hi)
    );

    xce_core #(.NSRC(NSRC), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ptr(ptr),
        .fill_dst(fill_dst), .fill_size(fill_size), .fill_lo(fill_lo), .fill_hi(fill_hi),
        .ptr_take(ptr_take), .busy(busy), .curr(curr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .eod(eod_pulse), .eoc(eoc_pulse)
    );
endmodule

// File: tb/tb_xor_copy_engine.sv
module tb_xor_copy_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8, MINB = 8, MAXB = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_waddr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_we, mem_ack, eod_pulse, eoc_pulse;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] mem [0:1023];
    logic [7:0] lfsr = 8'h5A;
    logic pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int n_eod = 0, n_eoc = 0, n_rd = 0, hold_viol = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    xor_copy_engine #(.NSRC(NSRC), .MIN_BYTES(MINB), .MAX_BYTES(MAXB)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .eod_pulse(eod_pulse), .eoc_pulse(eoc_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    assign mem_ack   = mem_req & (lfsr[0] | lfsr[1]);
    assign mem_rdata = mem[mem_addr[11:2]];

    // Memory model, stall generator and event counters
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
        if (rst_n) begin
            if (eod_pulse) n_eod <= n_eod + 1;
            if (eoc_pulse) n_eoc <= n_eoc + 1;
            if (mem_req && !mem_we && mem_ack) n_rd <= n_rd + 1;
            if (pend && (!mem_req || mem_addr != pend_addr)) hold_viol <= hold_viol + 1;
            pend <= mem_req && !mem_ack;
            pend_addr <= mem_addr;
        end
    end

    function automatic logic [31:0] sval(int i, int w);
        return (32'(i + 1) * 32'h0103_0507) ^ (32'h1 << ((i * 3 + w) % 32));
    endfunction
    function automatic logic [31:0] xexp(logic [7:0] m, int w);
        logic [31:0] r = '0;
        for (int i = 0; i < NSRC; i++) if (m[i]) r ^= sval(i, w);
        return r;
    endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask
    task automatic reg_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask
    task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_raddr = a; #1; d = reg_rdata;
    endtask
    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 20000; k++) begin
            reg_rd(3'd1, v);
            if (v[5:4] == 2'b00) break;
        end
        repeat (3) @(negedge clk);
    endtask
    // Descriptor: word 0 status, 1 command, 2 count, 3 dest, 4 link, 5.. sources
    task automatic mk_desc(int base, logic [7:0] m, int cnt, int dst, int nxt);
        mem[base/4 + 0] = 32'h8000_0000;
        mem[base/4 + 1] = 32'h8000_0000 | 32'(m);
        mem[base/4 + 2] = 32'(cnt);
        mem[base/4 + 3] = 32'(dst);
        mem[base/4 + 4] = 32'(nxt);
        for (int i = 0; i < NSRC; i++) mem[base/4 + 5 + i] = 32'h400 + 32'(i * 64);
    endtask
    task automatic fill_sent(int dst, int n);
        for (int w = 0; w < n; w++) mem[dst/4 + w] = 32'hDEAD_BEEF;
    endtask
    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int e0, c0, r0;
        for (int a = 0; a < 1024; a++) mem[a] = '0;
        for (int i = 0; i < NSRC; i++)
            for (int w = 0; w < 16; w++) mem[256 + i * 16 + w] = sval(i, w);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(3'd1, v); chk("R1 ctrl", v, 32'h0);
        reg_rd(3'd0, v); chk("R1 cfg", v, 32'h0);
        reg_rd(3'd3, v); chk("R1 cur", v, 32'h0);
        chk("R1 req", {31'd0, mem_req}, 32'h0);

        // R2 configuration readback
        reg_wr(3'd0, 32'hABCD_0001);
        reg_rd(3'd0, v); chk("R2 cfg readback", v, 32'hABCD_0001);
        reg_wr(3'd0, 32'h1);

        // R4 R5 R7 R8: sweep every source mask, single-descriptor chains
        for (int m = 0; m < 256; m++) begin
            mk_desc(0, 8'(m), 8, 32'h800, 0);
            fill_sent(32'h800, 2);
            e0 = n_eod; c0 = n_eoc;
            reg_wr(3'd2, 32'h0);
            reg_wr(3'd2, 32'h0 + 32'h0);
            mem[0] = 32'h8000_0000;
            reg_wr(3'd2, 32'h0);
            // descriptor sits at 0x000, so point through a nonzero alias base
            mk_desc(32'h100, 8'(m), 8, 32'h800, 0);
            reg_wr(3'd2, 32'h100);
            reg_wr(3'd1, 32'h1);
            wait_idle();
            chk("R5 xor word0", mem[512], xexp(8'(m), 0));
            chk("R5 xor word1", mem[513], xexp(8'(m), 1));
            chk("R7 status", mem[64], 32'h0);
            chk("R8 eod+eoc same run", 32'((n_eod - e0) * 16 + (n_eoc - c0)), 32'h11);
        end

        // R3 busy state, ignored start while busy; R11 count equal to MAX accepted
        mk_desc(32'h100, 8'h03, MAXB, 32'h800, 0);
        mk_desc(32'h180, 8'h01, 8, 32'h880, 0);
        e0 = n_eod;
        reg_wr(3'd2, 32'h100);
        reg_wr(3'd1, 32'h1);
        reg_rd(3'd1, v); chk("R3 busy bits", v, 32'h10);
        reg_wr(3'd2, 32'h180);
        reg_wr(3'd1, 32'h1);
        wait_idle();
        reg_rd(3'd1, v); chk("R3 idle bits", v, 32'h0);
        reg_rd(3'd2, v); chk("R3 ptr not consumed", v, 32'h180);
        chk("R3 second desc untouched", mem[32'h180/4], 32'h8000_0000);
        chk("R3 one descriptor", 32'(n_eod - e0), 32'd1);
        for (int w = 0; w < MAXB / 4; w++) chk("R11 max count data", mem[512 + w], xexp(8'h03, w));
        reg_wr(3'd2, 32'h0);

        // R6 copy mode ignores command bits
        reg_wr(3'd0, 32'h0);
        mk_desc(32'h100, 8'hFE, 16, 32'h800, 0);
        reg_wr(3'd2, 32'h100); reg_wr(3'd1, 32'h1); wait_idle();
        for (int w = 0; w < 4; w++) chk("R6 copy", mem[512 + w], sval(0, w));

        // R8 R9 three-descriptor chain in XOR mode
        reg_wr(3'd0, 32'h1);
        mk_desc(32'h000, 8'h0F, 8, 32'h800, 32'h040);
        mk_desc(32'h040, 8'h81, 12, 32'h840, 32'h080);
        mk_desc(32'h080, 8'hFF, 16, 32'h880, 0);
        e0 = n_eod; c0 = n_eoc;
        reg_wr(3'd2, 32'h0); reg_wr(3'd2, 32'h40);
        mem[32'h000/4 + 4] = 32'h040;
        reg_wr(3'd2, 32'h0);
        // start through the first descriptor: base 0 is the null link, so use 0x040 chain head alias
        mk_desc(32'h140, 8'h0F, 8, 32'h800, 32'h040);
        reg_wr(3'd2, 32'h140); reg_wr(3'd1, 32'h1); wait_idle();
        chk("R8 chain eod count", 32'(n_eod - e0), 32'd3);
        chk("R8 chain eoc count", 32'(n_eoc - c0), 32'd1);
        reg_rd(3'd3, v); chk("R9 current descriptor", v, 32'h080);
        for (int w = 0; w < 2; w++) chk("R8 d0", mem[512 + w], xexp(8'h0F, w));
        for (int w = 0; w < 3; w++) chk("R8 d1", mem[528 + w], xexp(8'h81, w));
        for (int w = 0; w < 4; w++) chk("R8 d2", mem[544 + w], xexp(8'hFF, w));
        chk("R7 tail status", mem[32'h080/4], 32'h0);
        reg_rd(3'd2, v); chk("R12 ptr cleared", v, 32'h0);

        // R12 resume from an appended tail, then a start with nothing appended
        mk_desc(32'h0C0, 8'h11, 8, 32'h8C0, 0);
        mem[32'h080/4 + 4] = 32'h0C0;
        e0 = n_eod; c0 = n_eoc;
        reg_wr(3'd1, 32'h1); wait_idle();
        reg_rd(3'd3, v); chk("R12 resumed cur", v, 32'h0C0);
        for (int w = 0; w < 2; w++) chk("R12 resumed data", mem[560 + w], xexp(8'h11, w));
        chk("R12 resumed eod", 32'(n_eod - e0), 32'd1);
        e0 = n_eod; c0 = n_eoc;
        reg_wr(3'd1, 32'h1); wait_idle();
        chk("R12 no pulses", 32'((n_eod - e0) + (n_eoc - c0)), 32'd0);
        reg_rd(3'd3, v); chk("R12 cur held", v, 32'h0C0);

        // R11 bad byte counts skip data but complete with error flag
        mk_desc(32'h000 + 32'h200, 8'h01, 6,        32'h900, 32'h240);
        mk_desc(32'h240, 8'h01, MINB - 4, 32'h940, 32'h280);
        mk_desc(32'h280, 8'h01, MAXB + 4, 32'h980, 32'h2C0);
        mk_desc(32'h2C0, 8'h03, MINB,     32'h9C0, 0);
        fill_sent(32'h900, 2); fill_sent(32'h940, 1); fill_sent(32'h980, 2);
        e0 = n_eod;
        reg_wr(3'd2, 32'h200); reg_wr(3'd1, 32'h1); wait_idle();
        chk("R11 unaligned status", mem[32'h200/4], 32'h4000_0000);
        chk("R11 short status", mem[32'h240/4], 32'h4000_0000);
        chk("R11 long status", mem[32'h280/4], 32'h4000_0000);
        chk("R11 good status", mem[32'h2C0/4], 32'h0);
        chk("R11 unaligned no data", mem[32'h900/4], 32'hDEAD_BEEF);
        chk("R11 short no data", mem[32'h940/4], 32'hDEAD_BEEF);
        chk("R11 long no data", mem[32'h980/4], 32'hDEAD_BEEF);
        chk("R11 min count data", mem[32'h9C0/4 + 1], xexp(8'h03, 1));
        chk("R11 chain continued", 32'(n_eod - e0), 32'd4);

        // R10 fill mode from registers
        reg_wr(3'd0, 32'h4);
        reg_wr(3'd4, 32'hA00); reg_wr(3'd5, 32'd20);
        reg_wr(3'd6, 32'h1122_3344); reg_wr(3'd7, 32'h5566_7788);
        fill_sent(32'hA00, 6);
        e0 = n_eod; c0 = n_eoc; r0 = n_rd;
        reg_wr(3'd1, 32'h1); wait_idle();
        for (int w = 0; w < 5; w++)
            chk("R10 fill word", mem[32'hA00/4 + w], (w % 2 == 0) ? 32'h1122_3344 : 32'h5566_7788);
        chk("R10 fill bound", mem[32'hA00/4 + 5], 32'hDEAD_BEEF);
        chk("R10 no reads", 32'(n_rd - r0), 32'd0);
        chk("R10 no eod", 32'(n_eod - e0), 32'd0);
        chk("R10 one eoc", 32'(n_eoc - c0), 32'd1);
        reg_rd(3'd3, v); chk("R10 cur unchanged", v, 32'h2C0);

        // R11 fill sizes that break the length rule
        reg_wr(3'd5, 32'd4);
        fill_sent(32'hA00, 2);
        c0 = n_eoc;
        reg_wr(3'd1, 32'h1); wait_idle();
        reg_wr(3'd5, 32'd10);
        reg_wr(3'd1, 32'h1); wait_idle();
        chk("R11 bad fill no write", mem[32'hA00/4], 32'hDEAD_BEEF);
        chk("R11 bad fill eoc", 32'(n_eoc - c0), 32'd2);

        // R13 request hold under stalls
        chk("R13 hold violations", 32'(hold_viol), 32'd0);

        finish_run();
    end
endmodule